// File: doc/BRIEF.md
# 100 Mb/s 4B/5B Coding Sublayer

This block sits between a nibble-wide media-independent interface and a 5-bit code-group stream that is already aligned to the MII clock. On the transmit side it turns every nibble into its 5-bit code group. It puts a start delimiter in front of each frame and an end delimiter after it, and it sends idle code groups between frames. On the receive side it finds the start delimiter and decodes data code groups back into nibbles. From the code-group stream it derives carrier sense, receive-data-valid and receive-error, and it flags a carrier that ends without an end delimiter.

In half duplex a collision output is raised while transmission and received carrier overlap. A test-bypass input turns the coding off entirely. Transmit nibbles and receive code groups are then passed through unchanged, with the fifth bit carrying the enable or the error flag.

All outputs except the collision flag come from registers. They reflect the inputs sampled at the previous rising clock edge.

Top module: `pcs4b5b_framer`

## Requirements
- R1: While reset is low, tx_code is IDLE (11111), rxd is 0000, and rx_dv, rx_er and crs are low.
- R2: With bypass low and no frame in progress, tx_en low yields IDLE (11111) on tx_code one cycle later.
- R3: The first nibble of a frame (tx_en rising) is sent as J (11000) and the second as K (10001), whatever txd holds. Later nibbles are sent as their data codes: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R4: In the cycle after tx_en falls, T (01101) is sent, then R (00111), then IDLE.
- R5: A data nibble presented with tx_er high is sent as H (00100) in place of its data code.
- R6: A received J raises crs with rxd 0101 and rx_dv low. A K that follows raises rx_dv with rxd 0101. Data codes that follow give rx_dv high and the decoded nibble on rxd. Each output appears one cycle after its code group.
- R7: In a frame, a received T drops rx_dv while crs stays high. An R that follows drops crs. Neither raises rx_er.
- R8: IDLE received in a frame without a preceding T drops crs and rx_dv and raises rx_er for exactly one cycle.
- R9: A code group that is neither a data code, T nor IDLE, received in a frame, raises rx_er while rx_dv and crs stay high. The next valid data code clears rx_er.
- R10: col is high exactly when tx_en and crs are both high and full_duplex is low, in the same cycle.
- R11: With bypass high, tx_code is {tx_er, txd} one cycle later. rxd is rx_code[3:0], and rx_dv and crs both equal rx_code[4], one cycle later. rx_er stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | Test bypass of the coding function |
| full_duplex | input | 1 | High suppresses collision indication |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit nibble |
| tx_code | output | 5 | Transmit code group |
| rx_code | input | 5 | Received code group |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
The premature end of carrier is the case that is hardest to reach. It needs the receiver to be inside a confirmed frame and then see IDLE without the T that normally closes the frame. The stimulus therefore feeds J, K and one data code before dropping straight to IDLE. It then checks that rx_er is high for that one cycle and low on the following one. Collision is reached by holding tx_en through a received start delimiter, and full_duplex is then toggled in the middle of the overlap.

// File: rtl/pcs4b5b_framer.sv
module pcs4b5b_framer #(
  parameter int NW = 4,
  parameter int CW = NW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic          full_duplex,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic [NW-1:0] txd,
  output logic [CW-1:0] tx_code,
  input  logic [CW-1:0] rx_code,
  output logic [NW-1:0] rxd,
  output logic          rx_dv,
  output logic          rx_er,
  output logic          crs,
  output logic          col
);
  localparam logic [CW-1:0] C_IDLE = 5'b11111;
  localparam logic [CW-1:0] C_J    = 5'b11000;
  localparam logic [CW-1:0] C_K    = 5'b10001;
  localparam logic [CW-1:0] C_T    = 5'b01101;
  localparam logic [CW-1:0] C_R    = 5'b00111;
  localparam logic [CW-1:0] C_H    = 5'b00100;
  localparam logic [NW-1:0] PRE_NIB = 4'b0101;

  function automatic logic [CW-1:0] enc5(input logic [NW-1:0] n);
    case (n)
      4'h0: enc5 = 5'b11110;  4'h1: enc5 = 5'b01001;
      4'h2: enc5 = 5'b10100;  4'h3: enc5 = 5'b10101;
      4'h4: enc5 = 5'b01010;  4'h5: enc5 = 5'b01011;
      4'h6: enc5 = 5'b01110;  4'h7: enc5 = 5'b01111;
      4'h8: enc5 = 5'b10010;  4'h9: enc5 = 5'b10011;
      4'hA: enc5 = 5'b10110;  4'hB: enc5 = 5'b10111;
      4'hC: enc5 = 5'b11010;  4'hD: enc5 = 5'b11011;
      4'hE: enc5 = 5'b11100;  default: enc5 = 5'b11101;
    endcase
  endfunction

  function automatic logic [NW:0] dec5(input logic [CW-1:0] c);
    dec5 = '0;
    for (int i = 0; i < 16; i++)
      if (enc5(NW'(i)) == c) dec5 = {1'b1, NW'(i)};
  endfunction

  typedef enum logic [1:0] {TX_IDLE, TX_K, TX_DATA, TX_R} tx_st_t;
  typedef enum logic [1:0] {RX_IDLE, RX_J, RX_FRAME, RX_T} rx_st_t;

  tx_st_t tx_st;
  rx_st_t rx_st;
  logic [NW:0] rx_dec;

  assign rx_dec = dec5(rx_code);
  assign col    = tx_en & crs & ~full_duplex;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st   <= TX_IDLE;
      tx_code <= C_IDLE;
    end else if (bypass) begin
      tx_st   <= TX_IDLE;
      tx_code <= {tx_er, txd};
    end else begin
      case (tx_st)
        TX_IDLE: begin
          tx_code <= tx_en ? C_J : C_IDLE;
          if (tx_en) tx_st <= TX_K;
        end
        TX_K: begin
          tx_code <= tx_en ? C_K : C_T;
          tx_st   <= tx_en ? TX_DATA : TX_R;
        end
        TX_DATA: begin
          if (tx_en) tx_code <= tx_er ? C_H : enc5(txd);
          else begin
            tx_code <= C_T;
            tx_st   <= TX_R;
          end
        end
        default: begin
          tx_code <= C_R;
          tx_st   <= TX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE;
      rxd   <= '0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
      crs   <= 1'b0;
    end else if (bypass) begin
      rx_st <= RX_IDLE;
      rxd   <= rx_code[NW-1:0];
      rx_dv <= rx_code[NW];
      crs   <= rx_code[NW];
      rx_er <= 1'b0;
    end else begin
      rx_er <= 1'b0;
      rx_dv <= 1'b0;
      rxd   <= '0;
      case (rx_st)
        RX_IDLE: begin
          if (rx_code == C_J) begin
            crs   <= 1'b1;
            rxd   <= PRE_NIB;
            rx_st <= RX_J;
          end else crs <= 1'b0;
        end
        RX_J: begin
          if (rx_code == C_K) begin
            crs   <= 1'b1;
            rx_dv <= 1'b1;
            rxd   <= PRE_NIB;
            rx_st <= RX_FRAME;
          end else begin
            crs   <= 1'b0;
            rx_st <= RX_IDLE;
          end
        end
        RX_FRAME: begin
          if (rx_dec[NW]) begin
            rx_dv <= 1'b1;
            rxd   <= rx_dec[NW-1:0];
          end else if (rx_code == C_T) begin
            rx_st <= RX_T;
          end else if (rx_code == C_IDLE) begin
            crs   <= 1'b0;
            rx_er <= 1'b1;
            rx_st <= RX_IDLE;
          end else begin
            rx_dv <= 1'b1;
            rx_er <= 1'b1;
          end
        end
        default: begin
          crs   <= 1'b0;
          rx_er <= (rx_code != C_R);
          rx_st <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

module pcs4b5b_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bypass,
  input logic [4:0] tx_code,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       crs
);
  function automatic logic legal5(input logic [4:0] c);
    case (c)
      5'b11111, 5'b11000, 5'b10001, 5'b01101, 5'b00111, 5'b00100,
      5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
      5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101: legal5 = 1'b1;
      default: legal5 = 1'b0;
    endcase
  endfunction

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bypass) |-> legal5(tx_code));

  p_jk_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 5'b11000 && !$past(bypass) && !bypass) |=>
      (tx_code == 5'b10001 || tx_code == 5'b01101));

  p_tr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 5'b01101 && !$past(bypass) && !bypass) |=> tx_code == 5'b00111);

  p_dv_has_crs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  p_er_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !crs) |=> !rx_er);
endmodule

bind pcs4b5b_framer pcs4b5b_framer_chk u_chk (.*);

// File: tb/pcs4b5b_framer_tb.sv
`timescale 1ns/1ps
module pcs4b5b_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bypass = 1'b0, full_duplex = 1'b0;
  logic tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = '0;
  logic [4:0] rx_code = 5'b11111;
  logic [4:0] tx_code;
  logic [3:0] rxd;
  logic rx_dv, rx_er, crs, col;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pcs4b5b_framer dut_i (.clk, .rst_n, .bypass, .full_duplex, .tx_en, .tx_er,
    .txd, .tx_code, .rx_code, .rxd, .rx_dv, .rx_er, .crs, .col);

  function automatic logic [4:0] code_of(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tx_step(input logic en, input logic er, input logic [3:0] d,
                         input logic [4:0] exp, input string tag);
    tx_en = en; tx_er = er; txd = d;
    tick();
    chk(tx_code, exp, tag);
  endtask

  task automatic rx_step(input logic [4:0] c, input logic e_crs, input logic e_dv,
                         input logic e_er, input logic [3:0] e_rxd, input logic ck_rxd,
                         input string tag);
    rx_code = c;
    tick();
    chk({2'b0, crs, rx_dv, rx_er}, {2'b0, e_crs, e_dv, e_er}, tag);
    if (ck_rxd) chk({1'b0, rxd}, {1'b0, e_rxd}, tag);
  endtask

  task automatic t_reset();
    chk(tx_code, 5'b11111, "R1 tx_code");
    chk({1'b0, rxd}, 5'b0, "R1 rxd");
    chk({1'b0, crs, rx_dv, rx_er, col}, 5'b0, "R1 flags");
  endtask

  task automatic t_tx_idle();
    for (int i = 0; i < 3; i++) tx_step(1'b0, 1'b0, 4'h9, 5'b11111, "R2 idle");
  endtask

  task automatic t_tx_frame();
    logic [3:0] ds [4] = '{4'h0, 4'hF, 4'hA, 4'h3};
    tx_step(1'b1, 1'b0, 4'h5, 5'b11000, "R3 J");
    tx_step(1'b1, 1'b0, 4'h5, 5'b10001, "R3 K");
    foreach (ds[i]) tx_step(1'b1, 1'b0, ds[i], code_of(ds[i]), "R3 data");
    tx_step(1'b0, 1'b0, 4'h0, 5'b01101, "R4 T");
    tx_step(1'b0, 1'b0, 4'h0, 5'b00111, "R4 R");
    tx_step(1'b0, 1'b0, 4'h0, 5'b11111, "R4 idle");
  endtask

  task automatic t_tx_err();
    tx_step(1'b1, 1'b1, 4'h5, 5'b11000, "R5 J kept");
    tx_step(1'b1, 1'b0, 4'h5, 5'b10001, "R5 K");
    tx_step(1'b1, 1'b0, 4'h7, code_of(4'h7), "R5 data");
    tx_step(1'b1, 1'b1, 4'h7, 5'b00100, "R5 H");
    tx_step(1'b1, 1'b0, 4'hE, code_of(4'hE), "R5 data after");
    tx_step(1'b0, 1'b0, 4'h0, 5'b01101, "R5 T");
    tx_step(1'b0, 1'b0, 4'h0, 5'b00111, "R5 R");
  endtask

  task automatic t_rx_frame();
    rx_step(5'b11000, 1, 0, 0, 4'h5, 1, "R6 J");
    rx_step(5'b10001, 1, 1, 0, 4'h5, 1, "R6 K");
    rx_step(code_of(4'h7), 1, 1, 0, 4'h7, 1, "R6 data7");
    rx_step(code_of(4'hC), 1, 1, 0, 4'hC, 1, "R6 dataC");
    rx_step(5'b01101, 1, 0, 0, 4'h0, 0, "R7 T");
    rx_step(5'b00111, 0, 0, 0, 4'h0, 0, "R7 R");
    rx_step(5'b11111, 0, 0, 0, 4'h0, 0, "R7 idle");
  endtask

  task automatic t_rx_premature();
    rx_step(5'b11000, 1, 0, 0, 4'h5, 0, "R8 J");
    rx_step(5'b10001, 1, 1, 0, 4'h5, 0, "R8 K");
    rx_step(code_of(4'h2), 1, 1, 0, 4'h2, 1, "R8 data");
    rx_step(5'b11111, 0, 0, 1, 4'h0, 0, "R8 premature");
    rx_step(5'b11111, 0, 0, 0, 4'h0, 0, "R8 single pulse");
  endtask

  task automatic t_rx_invalid();
    rx_step(5'b11000, 1, 0, 0, 4'h5, 0, "R9 J");
    rx_step(5'b10001, 1, 1, 0, 4'h5, 0, "R9 K");
    rx_step(5'b00000, 1, 1, 1, 4'h0, 0, "R9 invalid");
    rx_step(5'b00100, 1, 1, 1, 4'h0, 0, "R9 H received");
    rx_step(code_of(4'h9), 1, 1, 0, 4'h9, 1, "R9 recover");
    rx_step(5'b01101, 1, 0, 0, 4'h0, 0, "R9 T");
    rx_step(5'b00111, 0, 0, 0, 4'h0, 0, "R9 R");
  endtask

  task automatic t_col();
    full_duplex = 1'b0; tx_en = 1'b1; rx_code = 5'b11000;
    tick();
    chk({4'b0, col}, 5'd1, "R10 overlap");
    rx_code = 5'b10001;
    full_duplex = 1'b1; #1;
    chk({4'b0, col}, 5'd0, "R10 full duplex");
    tick();
    full_duplex = 1'b0; tx_en = 1'b0; #1;
    chk({4'b0, col}, 5'd0, "R10 tx off");
    tick();
    chk({3'b0, crs, col}, 5'b00010, "R10 crs only");
    rx_code = 5'b01101; tick();
    rx_code = 5'b00111; tick();
    rx_code = 5'b11111;
    for (int i = 0; i < 3; i++) tick();
    chk({3'b0, crs, col}, 5'd0, "R10 quiet");
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    tx_en = 1'b0; tx_er = 1'b1; txd = 4'h6; rx_code = 5'b11001;
    tick();
    chk(tx_code, 5'b10110, "R11 tx raw");
    chk({1'b0, rxd}, 5'h9, "R11 rxd raw");
    chk({2'b0, crs, rx_dv, rx_er}, 5'b00110, "R11 flags high");
    tx_er = 1'b0; txd = 4'hB; rx_code = 5'b00011;
    tick();
    chk(tx_code, 5'b01011, "R11 tx raw2");
    chk({1'b0, rxd}, 5'h3, "R11 rxd raw2");
    chk({2'b0, crs, rx_dv, rx_er}, 5'b0, "R11 flags low");
    bypass = 1'b0; txd = 4'h0; rx_code = 5'b11111;
    tick(); tick();
    chk(tx_code, 5'b11111, "R11 back to idle");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    t_tx_idle();
    t_tx_frame();
    t_tx_err();
    t_rx_frame();
    t_rx_premature();
    t_rx_invalid();
    t_col();
    t_bypass();
    finish_run();
  end
endmodule